// File: doc/BRIEF.md
# CAN Transmit Mailbox Status Controller

This block sits between software and a CAN protocol engine and tracks a bank of transmit message slots. Software arms a slot by setting its request flag through a synchronous write port. When the engine signals that the bus is idle, the block picks one eligible slot, marks it active and tells the engine which slot to send. The engine then reports the start of the frame, and after that either a lost arbitration or a successful completion. The block updates the slot flags and a channel status from these reports.

The channel status has three parts: a transmitter-busy bit, a sticky success flag and the number of the last slot that was sent. On each success the block can also raise a one-cycle interrupt request, gated by an enable input. After a slot has been sent, software must clear both its sent flag and its request flag before the slot can be armed again. Bit timing, framing, CRC, reception and error counting are the job of the engine and are not part of this block.

Top module: `can_tx_mailbox_ctrl`

## Requirements
- R1: A synchronous reset clears every slot's request, active and sent flags, and clears the busy bit, the success flag, the last-slot field, the interrupt request and the start pulse.
- R2: A write to a slot with wrReq=0 clears its request flag. A write with wrSent=0 clears its sent flag. A write with wrSent=1 leaves the sent flag unchanged. Writes take effect at the clock edge, and the read port shows the flags of slot rdSlot combinationally.
- R3: A write with wrReq=1 to a slot whose sent flag is 1 leaves that slot's request flag unchanged. Once both flags read 0, a write with wrReq=1 sets the request flag.
- R4: When the block is idle and busIdle is high at a clock edge while at least one slot is eligible (request 1, sent 0), the following happens after that edge: the lowest-numbered eligible slot has its active flag at 1, txState is 1, and txGo is high for exactly one cycle with txSlot giving the slot number. If no slot is eligible, nothing starts.
- R5: A slot whose sent flag is 1 is never selected, even if its request flag is still 1.
- R6: At most one slot is active. A busIdle that arrives while a transmission is pending or on the bus is ignored.
- R7: An arbLost report after sofSeen clears the slot's active flag and txState. The request flag is kept, so the slot is selected again at the next bus idle.
- R8: A txOk report after sofSeen does the following at the same clock edge: it sets the slot's sent flag, clears its active flag and txState, sets txSucc, and loads lastSlot with the slot number.
- R9: txDoneIrq is high for exactly one cycle after a success, and only if intEn was 1 at that success edge.
- R10: arbLost and txOk reports that arrive before sofSeen for the current transmission are ignored.
- R11: txSucc and lastSlot keep their values through lost arbitrations, software writes and idle periods, and change only on a successful transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe for a slot's control flags |
| wrSlot | input | 4 | Slot index for the write |
| wrReq | input | 1 | Request value to write |
| wrSent | input | 1 | Sent value to write (0 clears, 1 keeps) |
| rdSlot | input | 4 | Slot index for the read port |
| rdReq | output | 1 | Request flag of slot rdSlot |
| rdActive | output | 1 | Active flag of slot rdSlot |
| rdSent | output | 1 | Sent flag of slot rdSlot |
| intEn | input | 1 | Successful-transmit interrupt enable |
| busIdle | input | 1 | Engine: bus is idle, a transmission may begin |
| sofSeen | input | 1 | Engine: start of frame sent for the current slot |
| arbLost | input | 1 | Engine: arbitration lost |
| txOk | input | 1 | Engine: frame sent successfully |
| txGo | output | 1 | One-cycle start pulse to the engine |
| txSlot | output | 4 | Slot being handed to the engine |
| txState | output | 1 | Transmitter busy |
| txSucc | output | 1 | Sticky success flag |
| lastSlot | output | 4 | Number of the last slot sent |
| txDoneIrq | output | 1 | Successful-transmit interrupt request |

## Verification
The bench uses the default of sixteen slots, so the slot index is four bits wide. This lets it arm slot 15, the lowest-priority slot, and see it win only after every lower slot has been cleared or marked sent. It also makes lastSlot show a value that uses every bit of its field. Two slots, 5 and 9, are requested together so that the priority choice, a lost arbitration with a retry, and the exclusion of a slot already sent can all be seen on the same pair.

// File: rtl/cantx_pkg.sv
package cantx_pkg;

  typedef enum logic [1:0] {
    CT_IDLE  = 2'd0,
    CT_ARMED = 2'd1,
    CT_ONBUS = 2'd2
  } ctState_t;

  // Strobes from the sequencer to the flag datapath
  typedef struct packed {
    logic start;
    logic lost;
    logic done;
  } ctStrobe_t;

endpackage

// File: rtl/cantx_seq_ctrl.sv
module cantx_seq_ctrl
  import cantx_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 busIdle,
  input  logic                 sofSeen,
  input  logic                 arbLost,
  input  logic                 txOk,
  input  logic [NUM_SLOTS-1:0] eligVec,
  output ctStrobe_t            strobe,
  output logic [SLOT_W-1:0]    slotSel,
  output logic [SLOT_W-1:0]    curSlot,
  output logic                 txGo
);

  ctState_t            state;
  logic [SLOT_W-1:0]   pickIdx;
  logic                anyElig;

  // lowest-numbered eligible slot wins
  always_comb begin
    pickIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (eligVec[i]) pickIdx = SLOT_W'(i);
    end
  end

  assign anyElig = |eligVec;

  always_comb begin
    strobe = '0;
    unique case (state)
      CT_IDLE:  strobe.start = busIdle && anyElig;
      CT_ONBUS: begin
        strobe.lost = arbLost;
        strobe.done = !arbLost && txOk;
      end
      default: ;
    endcase
  end

  assign slotSel = (state == CT_IDLE) ? pickIdx : curSlot;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= CT_IDLE;
      curSlot <= '0;
      txGo    <= 1'b0;
    end else begin
      txGo <= strobe.start;
      unique case (state)
        CT_IDLE: if (strobe.start) begin
          state   <= CT_ARMED;
          curSlot <= pickIdx;
        end
        CT_ARMED: if (sofSeen) state <= CT_ONBUS;
        CT_ONBUS: if (strobe.lost || strobe.done) state <= CT_IDLE;
        default: state <= CT_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cantx_slot_regs.sv
module cantx_slot_regs
  import cantx_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrEn,
  input  logic [SLOT_W-1:0]    wrSlot,
  input  logic                 wrReq,
  input  logic                 wrSent,
  input  logic [SLOT_W-1:0]    rdSlot,
  input  logic                 intEn,
  input  ctStrobe_t            strobe,
  input  logic [SLOT_W-1:0]    slotSel,
  output logic                 rdReq,
  output logic                 rdActive,
  output logic                 rdSent,
  output logic [NUM_SLOTS-1:0] eligVec,
  output logic                 txState,
  output logic                 txSucc,
  output logic [SLOT_W-1:0]    lastSlot,
  output logic                 txDoneIrq
);

  logic [NUM_SLOTS-1:0] reqVec;
  logic [NUM_SLOTS-1:0] actVec;
  logic [NUM_SLOTS-1:0] sentVec;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    logic wrHit;
    logic engHit;
    assign wrHit  = wrEn && (wrSlot == SLOT_W'(g));
    assign engHit = (slotSel == SLOT_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        reqVec[g]  <= 1'b0;
        actVec[g]  <= 1'b0;
        sentVec[g] <= 1'b0;
      end else begin
        if (wrHit) begin
          if (!wrReq)          reqVec[g] <= 1'b0;
          else if (!sentVec[g]) reqVec[g] <= 1'b1;
        end
        if (strobe.done && engHit)  sentVec[g] <= 1'b1;
        else if (wrHit && !wrSent)  sentVec[g] <= 1'b0;
        if (strobe.start && engHit) actVec[g] <= 1'b1;
        else if ((strobe.lost || strobe.done) && engHit) actVec[g] <= 1'b0;
      end
    end

    assign eligVec[g] = reqVec[g] && !sentVec[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txState   <= 1'b0;
      txSucc    <= 1'b0;
      lastSlot  <= '0;
      txDoneIrq <= 1'b0;
    end else begin
      txDoneIrq <= strobe.done && intEn;
      if (strobe.start) txState <= 1'b1;
      else if (strobe.lost || strobe.done) txState <= 1'b0;
      if (strobe.done) begin
        txSucc   <= 1'b1;
        lastSlot <= slotSel;
      end
    end
  end

  assign rdReq    = reqVec[rdSlot];
  assign rdActive = actVec[rdSlot];
  assign rdSent   = sentVec[rdSlot];

endmodule

// File: rtl/can_tx_mailbox_ctrl.sv
module can_tx_mailbox_ctrl
  import cantx_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic              wrReq,
  input  logic              wrSent,
  input  logic [SLOT_W-1:0] rdSlot,
  output logic              rdReq,
  output logic              rdActive,
  output logic              rdSent,
  input  logic              intEn,
  input  logic              busIdle,
  input  logic              sofSeen,
  input  logic              arbLost,
  input  logic              txOk,
  output logic              txGo,
  output logic [SLOT_W-1:0] txSlot,
  output logic              txState,
  output logic              txSucc,
  output logic [SLOT_W-1:0] lastSlot,
  output logic              txDoneIrq
);

  ctStrobe_t            strobe;
  logic [NUM_SLOTS-1:0] eligVec;
  logic [SLOT_W-1:0]    slotSel;

  cantx_seq_ctrl #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .busIdle (busIdle),
    .sofSeen (sofSeen),
    .arbLost (arbLost),
    .txOk    (txOk),
    .eligVec (eligVec),
    .strobe  (strobe),
    .slotSel (slotSel),
    .curSlot (txSlot),
    .txGo    (txGo)
  );

  cantx_slot_regs #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .wrEn      (wrEn),
    .wrSlot    (wrSlot),
    .wrReq     (wrReq),
    .wrSent    (wrSent),
    .rdSlot    (rdSlot),
    .intEn     (intEn),
    .strobe    (strobe),
    .slotSel   (slotSel),
    .rdReq     (rdReq),
    .rdActive  (rdActive),
    .rdSent    (rdSent),
    .eligVec   (eligVec),
    .txState   (txState),
    .txSucc    (txSucc),
    .lastSlot  (lastSlot),
    .txDoneIrq (txDoneIrq)
  );

endmodule

// File: rtl/cantx_checker.sv
module cantx_checker #(
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busIdle,
  input logic              arbLost,
  input logic              txOk,
  input logic              intEn,
  input logic              txGo,
  input logic              txState,
  input logic              txSucc,
  input logic [SLOT_W-1:0] lastSlot,
  input logic              txDoneIrq
);

  assert_go_busy_R4: assert property (@(posedge clk) disable iff (rst)
    txGo |-> (txState && $past(busIdle)));

  assert_go_single_R6: assert property (@(posedge clk) disable iff (rst)
    txGo |=> !txGo);

  assert_state_drop_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(txState) |-> ($past(arbLost) || $past(txOk)));

  assert_succ_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(txSucc) |-> $past(txOk));

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (rst)
    txDoneIrq |-> ($past(intEn) && $past(txOk) && txSucc));

  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    txDoneIrq |=> !txDoneIrq);

  assert_status_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(txOk) |-> ($stable(lastSlot) && $stable(txSucc)));

endmodule

bind can_tx_mailbox_ctrl cantx_checker #(.SLOT_W(SLOT_W)) i_checker (
  .clk       (clk),
  .rst       (rst),
  .busIdle   (busIdle),
  .arbLost   (arbLost),
  .txOk      (txOk),
  .intEn     (intEn),
  .txGo      (txGo),
  .txState   (txState),
  .txSucc    (txSucc),
  .lastSlot  (lastSlot),
  .txDoneIrq (txDoneIrq)
);

// File: tb/test_can_tx_mailbox_ctrl.sv
`timescale 1ns/1ps
module test_can_tx_mailbox_ctrl;

  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 0, wrReq = 0, wrSent = 0;
  logic [SW-1:0] wrSlot = '0, rdSlot = '0;
  logic intEn = 0, busIdle = 0, sofSeen = 0, arbLost = 0, txOk = 0;
  logic rdReq, rdActive, rdSent, txGo, txState, txSucc, txDoneIrq;
  logic [SW-1:0] txSlot, lastSlot;

  always #2.5 clk = ~clk;

  can_tx_mailbox_ctrl i_can_tx_mailbox_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSlot(wrSlot), .wrReq(wrReq),
    .wrSent(wrSent), .rdSlot(rdSlot), .rdReq(rdReq), .rdActive(rdActive),
    .rdSent(rdSent), .intEn(intEn), .busIdle(busIdle), .sofSeen(sofSeen),
    .arbLost(arbLost), .txOk(txOk), .txGo(txGo), .txSlot(txSlot),
    .txState(txState), .txSucc(txSucc), .lastSlot(lastSlot),
    .txDoneIrq(txDoneIrq)
  );

  // probe codes: 0 req,1 active,2 sent,3 txState,4 txSucc,5 lastSlot,
  //              6 txDoneIrq,7 txGo,8 txSlot
  typedef struct {
    string req;
    int    probe;
    int    expv;
  } item_t;

  item_t scoreQ[$];
  event  pushEv;
  int    nApplied = 0;
  int    nMiss = 0;
  bit    finished = 0;

  function automatic int sampleProbe(int p);
    case (p)
      0: return int'(rdReq);
      1: return int'(rdActive);
      2: return int'(rdSent);
      3: return int'(txState);
      4: return int'(txSucc);
      5: return int'(lastSlot);
      6: return int'(txDoneIrq);
      7: return int'(txGo);
      default: return int'(txSlot);
    endcase
  endfunction

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(pushEv);
      while (scoreQ.size() > 0) begin
        item_t it;
        int act;
        it  = scoreQ.pop_front();
        act = sampleProbe(it.probe);
        nApplied++;
        if (act != it.expv) begin
          nMiss++;
          $display("FAIL %s: probe %0d actual %0d expected %0d",
                   it.req, it.probe, act, it.expv);
        end
      end
    end
  end

  task automatic expect1(string req, int probe, int expv);
    item_t it;
    it.req = req; it.probe = probe; it.expv = expv;
    scoreQ.push_back(it);
    -> pushEv;
    #0;
  endtask

  task automatic expectSlot(string req, int slot, int r, int a, int s);
    rdSlot = SW'(slot);
    #0.1;
    expect1(req, 0, r);
    expect1(req, 1, a);
    expect1(req, 2, s);
  endtask

  task automatic expectChan(string req, int st, int sc, int ls);
    expect1(req, 3, st);
    expect1(req, 4, sc);
    expect1(req, 5, ls);
  endtask

  task automatic swWrite(int slot, bit r, bit s);
    wrEn = 1; wrSlot = SW'(slot); wrReq = r; wrSent = s;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic pulse(int which);
    case (which)
      0: busIdle = 1;
      1: sofSeen = 1;
      2: arbLost = 1;
      default: txOk = 1;
    endcase
    @(negedge clk);
    busIdle = 0; sofSeen = 0; arbLost = 0; txOk = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nMiss++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nApplied, nMiss);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    expectChan("R1", 0, 0, 0);
    expect1("R1", 6, 0);
    expect1("R1", 7, 0);
    expectSlot("R1", 0, 0, 0, 0);
    expectSlot("R1", 15, 0, 0, 0);

    // R4 nothing eligible: no start
    pulse(0);
    expect1("R4", 7, 0);
    expect1("R4", 3, 0);

    // R2 arm slots 5 and 9; write of sent=1 keeps sent at 0
    swWrite(9, 1, 0);
    swWrite(5, 1, 0);
    swWrite(3, 0, 1);
    expectSlot("R2", 5, 1, 0, 0);
    expectSlot("R2", 3, 0, 0, 0);

    // R4 lowest-numbered eligible slot picked
    pulse(0);
    expect1("R4", 7, 1);
    expect1("R4", 8, 5);
    expectChan("R4", 1, 0, 0);
    expectSlot("R4", 5, 1, 1, 0);
    expectSlot("R6", 9, 1, 0, 0);
    @(negedge clk);
    expect1("R4", 7, 0);

    // R6 bus idle ignored while pending
    pulse(0);
    expect1("R6", 7, 0);
    expectSlot("R6", 9, 1, 0, 0);

    // R10 success before start of frame ignored
    pulse(3);
    expectSlot("R10", 5, 1, 1, 0);
    expectChan("R10", 1, 0, 0);
    pulse(2);
    expectSlot("R10", 5, 1, 1, 0);

    // R7 lost arbitration after start of frame
    pulse(1);
    pulse(2);
    expectSlot("R7", 5, 1, 0, 0);
    expectChan("R11", 0, 0, 0);

    // R7 retried at next bus idle
    pulse(0);
    expect1("R7", 7, 1);
    expect1("R7", 8, 5);

    // R8/R9 success with interrupt enabled
    intEn = 1;
    pulse(1);
    pulse(3);
    expect1("R9", 6, 1);
    expectSlot("R8", 5, 1, 0, 1);
    expectChan("R8", 0, 1, 5);
    @(negedge clk);
    expect1("R9", 6, 0);

    // R5 sent slot skipped, slot 9 chosen
    pulse(0);
    expect1("R5", 7, 1);
    expect1("R5", 8, 9);
    pulse(1);
    pulse(2);
    expectChan("R11", 0, 1, 5);
    expectSlot("R11", 9, 1, 0, 0);

    // R3 re-arm rule
    swWrite(5, 0, 1);
    expectSlot("R3", 5, 0, 0, 1);
    swWrite(5, 1, 1);
    expectSlot("R3", 5, 0, 0, 1);
    swWrite(5, 0, 0);
    expectSlot("R2", 5, 0, 0, 0);
    swWrite(5, 1, 0);
    expectSlot("R3", 5, 1, 0, 0);
    expectChan("R11", 0, 1, 5);

    // R9 no interrupt when disabled
    swWrite(9, 0, 0);
    intEn = 0;
    pulse(0);
    expect1("R4", 8, 5);
    pulse(1);
    pulse(3);
    expect1("R9", 6, 0);
    expectChan("R8", 0, 1, 5);

    // R4 slot 15 is chosen once lower slots are done
    swWrite(5, 0, 0);
    swWrite(15, 1, 0);
    intEn = 1;
    pulse(0);
    expect1("R4", 8, 15);
    pulse(1);
    pulse(3);
    expect1("R9", 6, 1);
    expectChan("R8", 0, 1, 15);
    expectSlot("R8", 15, 1, 0, 1);

    // R1 reset again
    rst = 1;
    @(negedge clk);
    rst = 0;
    expectChan("R1", 0, 0, 0);
    expectSlot("R1", 15, 0, 0, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nApplied, nMiss);
    $finish;
  end

endmodule